// File: doc/BRIEF.md
# Burst SRAM Cycle Decoder

This block is the synchronous control front end of a burst static RAM. On every rising clock edge it samples two active-low address strobes, three chip enables, an advance input and the write controls. It classifies the edge as a new read, a new write, a burst continuation, a deselect or a blocked edge. The classification is registered. The block then presents an address-load pulse, an advance step, a four-lane write mask and a read-active flag. The processor-side strobe has priority and starts only reads. The controller-side strobe can start reads or writes.

The data-pin drive enable is not registered. It is the registered read-active flag gated by an asynchronous active-low output enable, so it follows that pin immediately. Burst address counting and the storage array sit outside this block and consume its outputs.

Top module: `sram_cycle_decoder`

## Requirements
- R1: While reset is low, and until the first edge after reset is released, addr_load, adv_step, wr_mask, rd_active and drv_en are all 0.
- R2: An edge with ads_p_n=0, cs_main_n=0, cs_hi=1 and cs_lo_n=0 starts a read. After that edge, addr_load=1, rd_active=1, wr_mask=4'b0000 and adv_step=0, whatever gw_n, bwe_n, bw_n and adv_n were.
- R3: An edge with ads_p_n=0 and cs_main_n=1 starts nothing, whatever ads_c_n is. After it, addr_load=0, adv_step=0 and wr_mask=0, and rd_active keeps its previous value.
- R4: An edge with ads_c_n=0 and ads_p_n=1 starts a cycle even when cs_main_n=1. If all three enables are active, addr_load=1 and adv_step=0 follow, and the write controls of that same edge set wr_mask as in R5.
- R5: The write mask has bit i for byte lane i. gw_n=0 gives 4'b1111. Otherwise, bwe_n=0 gives bit i = NOT bw_n[i]. Otherwise the mask is 4'b0000. On a controller start or a continuation edge, rd_active=1 exactly when the mask is 0000.
- R6: A start edge (R2 or R4 conditions on the strobes) with any enable inactive (cs_main_n=1, cs_hi=0 or cs_lo_n=1) is a deselect. After it, addr_load=0, wr_mask=0 and rd_active=0, and the burst session ends.
- R7: An edge with both strobes high inside a session is a continuation. After it, addr_load=0, adv_step = NOT adv_n, and wr_mask and rd_active follow R5.
- R8: drv_en equals rd_active AND NOT oe_n at all times, and it follows a change on oe_n with no clock edge.
- R9: An edge with both strobes high outside a session (after reset or a deselect) gives addr_load=0, adv_step=0, wr_mask=0 and rd_active=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ads_p_n | input | 1 | Processor-side address strobe, active low |
| ads_c_n | input | 1 | Controller-side address strobe, active low |
| cs_main_n | input | 1 | Master chip enable, active low |
| cs_hi | input | 1 | Secondary chip enable, active high |
| cs_lo_n | input | 1 | Secondary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Whole-word write enable, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | 4 | Per-lane byte write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr_load | output | 1 | Load external address this cycle |
| adv_step | output | 1 | Step the burst address this cycle |
| wr_mask | output | 4 | Per-lane write enables, lane i on bit i |
| rd_active | output | 1 | Current cycle is a read |
| drv_en | output | 1 | Drive the data pins |

## Verification
The properties assume that every input is a defined 0 or 1 at each sampling edge. They also assume that oe_n changes only away from the edge when drv_en is compared against it. The bench drives all inputs at the falling edge, so each sampled edge sees stable, fully specified values. The random mix biases both strobes low about a fifth of the time and the enables toward selection, so starts, deselects, blocked edges and long continuations all occur. Directed vectors cover the cases that random draws reach rarely: a processor start with every write control asserted, both strobes low with the master enable off, and a continuation after a deselect.

// File: rtl/sram_cycle_decoder.sv
module sram_cycle_decoder #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ads_p_n,
  input  logic             ads_c_n,
  input  logic             cs_main_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  output logic             addr_load,
  output logic             adv_step,
  output logic [LANES-1:0] wr_mask,
  output logic             rd_active,
  output logic             drv_en
);

  logic             sel_all, proc_go, ctrl_go, cont;
  logic             session_q;
  logic [LANES-1:0] req_mask;

  assign sel_all  = !cs_main_n && cs_hi && !cs_lo_n;
  assign proc_go  = !ads_p_n && !cs_main_n;
  assign ctrl_go  = ads_p_n && !ads_c_n;
  assign cont     = ads_p_n && ads_c_n;
  assign req_mask = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      session_q <= 1'b0;
      addr_load <= 1'b0;
      adv_step  <= 1'b0;
      wr_mask   <= '0;
      rd_active <= 1'b0;
    end else if (proc_go) begin
      session_q <= sel_all;
      addr_load <= sel_all;
      adv_step  <= 1'b0;
      wr_mask   <= '0;
      rd_active <= sel_all;
    end else if (ctrl_go) begin
      session_q <= sel_all;
      addr_load <= sel_all;
      adv_step  <= 1'b0;
      wr_mask   <= sel_all ? req_mask : '0;
      rd_active <= sel_all && (req_mask == '0);
    end else if (cont) begin
      addr_load <= 1'b0;
      adv_step  <= session_q && !adv_n;
      wr_mask   <= session_q ? req_mask : '0;
      rd_active <= session_q && (req_mask == '0);
    end else begin
      addr_load <= 1'b0;
      adv_step  <= 1'b0;
      wr_mask   <= '0;
    end
  end

  assign drv_en = rd_active && !oe_n;

endmodule

// File: rtl/sram_cycle_decoder_chk.sv
module sram_cycle_decoder_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ads_p_n,
  input logic             ads_c_n,
  input logic             cs_main_n,
  input logic             cs_hi,
  input logic             cs_lo_n,
  input logic             gw_n,
  input logic             oe_n,
  input logic             addr_load,
  input logic             adv_step,
  input logic [LANES-1:0] wr_mask,
  input logic             rd_active,
  input logic             drv_en
);

  logic sel;
  assign sel = !cs_main_n && cs_hi && !cs_lo_n;

  p_proc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_p_n && sel) |=> (addr_load && rd_active && wr_mask == '0 && !adv_step));

  p_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_p_n && cs_main_n) |=> (!addr_load && !adv_step && wr_mask == '0 && $stable(rd_active)));

  p_ctrl_global_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_p_n && !ads_c_n && sel && !gw_n) |=> (addr_load && wr_mask == '1 && !rd_active));

  p_write_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask != '0) |-> !rd_active);

  p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_start_n() || (ads_p_n && !ads_c_n)) && !sel) |=> (!addr_load && !rd_active && wr_mask == '0));

  p_load_no_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> !adv_step);

  p_drive_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || !rd_active) |-> !drv_en);

  function automatic logic proc_start_n();
    return !ads_p_n && !cs_main_n;
  endfunction

endmodule

bind sram_cycle_decoder sram_cycle_decoder_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ads_p_n(ads_p_n), .ads_c_n(ads_c_n),
  .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .gw_n(gw_n),
  .oe_n(oe_n), .addr_load(addr_load), .adv_step(adv_step), .wr_mask(wr_mask),
  .rd_active(rd_active), .drv_en(drv_en)
);

// File: tb/sram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module sram_cycle_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ads_p_n = 1, ads_c_n = 1, cs_main_n = 1, cs_hi = 0, cs_lo_n = 1;
  logic adv_n = 1, gw_n = 1, bwe_n = 1, oe_n = 1;
  logic [3:0] bw_n = 4'hF;
  logic addr_load, adv_step, rd_active, drv_en;
  logic [3:0] wr_mask;

  int vectors = 0, errors = 0;
  logic m_sess = 0, m_load = 0, m_step = 0, m_rd = 0;
  logic [3:0] m_mask = 0;
  string m_tag = "R1";

  always #2.5 clk = ~clk;

  sram_cycle_decoder u_sram_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .ads_p_n(ads_p_n), .ads_c_n(ads_c_n),
    .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .addr_load(addr_load), .adv_step(adv_step), .wr_mask(wr_mask),
    .rd_active(rd_active), .drv_en(drv_en));

  function automatic logic [3:0] lane_mask(logic g, logic b, logic [3:0] s);
    if (!g) return 4'hF;
    if (!b) return ~s;
    return 4'h0;
  endfunction

  function automatic logic enabled();
    return !cs_main_n && cs_hi && !cs_lo_n;
  endfunction

  task automatic model_edge();
    logic [3:0] w = lane_mask(gw_n, bwe_n, bw_n);
    if (!ads_p_n && !cs_main_n) begin
      m_sess = enabled(); m_load = enabled(); m_step = 0; m_mask = 0; m_rd = enabled();
      m_tag = enabled() ? "R2" : "R6";
    end else if (!ads_p_n) begin
      m_load = 0; m_step = 0; m_mask = 0; m_tag = "R3";
    end else if (!ads_c_n) begin
      m_sess = enabled(); m_load = enabled(); m_step = 0;
      m_mask = enabled() ? w : 4'h0; m_rd = enabled() && w == 0;
      m_tag = enabled() ? "R4" : "R6";
    end else begin
      m_load = 0; m_step = m_sess && !adv_n;
      m_mask = m_sess ? w : 4'h0; m_rd = m_sess && w == 0;
      m_tag = m_sess ? "R7" : "R9";
    end
    if (m_mask != 0 && m_tag == "R7") m_tag = "R5";
  endtask

  task automatic check_outputs(string tag);
    vectors++;
    if ({addr_load, adv_step, wr_mask, rd_active} !== {m_load, m_step, m_mask, m_rd}) begin
      errors++;
      $display("FAIL %s: load/step/mask/rd actual %b/%b/%h/%b expected %b/%b/%h/%b",
               tag, addr_load, adv_step, wr_mask, rd_active, m_load, m_step, m_mask, m_rd);
    end
  endtask

  task automatic check_drive();
    vectors++;
    if (drv_en !== (m_rd && !oe_n)) begin
      errors++;
      $display("FAIL R8: drv_en actual %b expected %b", drv_en, m_rd && !oe_n);
    end
  endtask

  task automatic apply(logic p, logic c, logic m, logic h, logic l, logic a,
                       logic g, logic b, logic [3:0] s, logic o);
    @(negedge clk);
    check_outputs(m_tag);
    check_drive();
    ads_p_n = p; ads_c_n = c; cs_main_n = m; cs_hi = h; cs_lo_n = l;
    adv_n = a; gw_n = g; bwe_n = b; bw_n = s; oe_n = o;
    #1 check_drive();
    model_edge();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outputs("R1");
    check_drive();
    rst_n = 1'b1;
    m_tag = "R1";
    // R2: processor start ignores every write control
    apply(0,1,0,1,0, 0, 0,0,4'h0, 0);
    // R7: continuation, advance low
    apply(1,1,0,1,0, 0, 1,1,4'hF, 0);
    // R5: continuation byte write lanes 0 and 2
    apply(1,1,0,1,0, 0, 1,0,4'b1010, 0);
    // R3: blocked processor strobe, controller also low
    apply(0,0,1,1,0, 0, 0,0,4'h0, 0);
    // R6 via R4: controller strobe with master enable off
    apply(1,0,1,1,0, 1, 1,1,4'hF, 0);
    // R9: continuation after deselect
    apply(1,1,0,1,0, 0, 0,0,4'h0, 0);
    // R4: controller start with global write
    apply(1,0,0,1,0, 0, 0,1,4'hF, 0);
    // R6: processor start with cs_hi low
    apply(0,1,0,0,0, 0, 1,1,4'hF, 0);
    // R4: controller start, byte strobes ignored without bwe
    apply(1,0,0,1,0, 1, 1,1,4'h0, 1);
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      apply($urandom_range(4) != 0, $urandom_range(4) != 0,
            $urandom_range(5) == 0, $urandom_range(6) != 0, $urandom_range(6) == 0,
            $urandom_range(1), $urandom_range(5) != 0, $urandom_range(1),
            4'($urandom_range(15)), $urandom_range(1));
    end
    apply(1,1,0,1,0, 1, 1,1,4'hF, 1);
    @(negedge clk);
    check_outputs(m_tag);
    check_drive();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule